// File: doc/BRIEF.md
# Frame Timestamp Capture and Descriptor Word Packer

This block records the moment a frame begins on each of two independent lanes, one for receive and one for transmit. When a lane's frame-start strobe is high, the block checks the frame's class (non-PTP, PTP general or PTP event) against that lane's 2-bit capture mode. If the mode admits the class, the block samples the live time-of-day counter on that same cycle. It then packs the sample into two 32-bit descriptor words, raises a one-cycle write strobe and sets a lane-specific valid flag word.

Only the nanoseconds field and the six least significant seconds bits are kept. Software rebuilds the full seconds value from the running counter. The write strobe is a plain pulse and the block has no back-pressure path. The descriptor writer downstream must accept every pulse in the cycle it appears. The words stay unchanged until the next admitted frame on that lane, so a writer that lags by a cycle still reads the right data.

Top module: `dts_stamp_capture`

## Requirements
- R1: A timestamp holds the counter value present on the cycle the lane's frame-start strobe is high. The write strobe is high for exactly the one cycle after that strobe cycle, and never otherwise.
- R2: Word 1 carries nanoseconds in bits 29:0 and seconds bits 1:0 in bits 31:30.
- R3: Word 2 carries seconds bits 5:2 in bits 3:0, and its bits 31:4 are always zero.
- R4: The receive flag word has only bit 2 set, and the transmit flag word has only bit 23 set, when that lane's last frame was stamped. A flag word is all zero otherwise.
- R5: Capture mode encoding: 0 stamps nothing. 1 stamps class 2 (PTP event) only. 2 stamps classes 1 and 2 (any PTP frame). 3 stamps every frame. Class 0 means non-PTP and class 3 is treated as non-PTP.
- R6: A frame whose class the mode rejects produces no write strobe and clears the valid bit and flag word. The two timestamp words keep their previous contents.
- R7: The mode and class are sampled only on the frame-start cycle. Changing the mode on any other cycle leaves the valid bit, flag word and timestamp words unchanged.
- R8: The receive and transmit lanes are independent. Frame starts on both lanes in the same cycle are each handled according to their own mode.
- R9: After reset, all words, strobes, valid bits and flag words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tod_sec_lo | input | 6 | Low seconds bits of the live time counter |
| tod_ns | input | 30 | Nanoseconds of the live time counter |
| rx_mode | input | 2 | Receive capture mode |
| tx_mode | input | 2 | Transmit capture mode |
| rx_sof | input | 1 | Receive frame-start strobe |
| rx_class | input | 2 | Receive frame class |
| tx_sof | input | 1 | Transmit frame-start strobe |
| tx_class | input | 2 | Transmit frame class |
| rx_wr | output | 1 | Receive timestamp write strobe |
| rx_valid | output | 1 | Receive last frame stamped |
| rx_word1 | output | 32 | Receive timestamp word 1 |
| rx_word2 | output | 32 | Receive timestamp word 2 |
| rx_flag | output | 32 | Receive valid flag word (bit 2) |
| tx_wr | output | 1 | Transmit timestamp write strobe |
| tx_valid | output | 1 | Transmit last frame stamped |
| tx_word1 | output | 32 | Transmit timestamp word 1 |
| tx_word2 | output | 32 | Transmit timestamp word 2 |
| tx_flag | output | 32 | Transmit valid flag word (bit 23) |

## Verification
The hardest case to produce is a rejected frame that directly follows a stamped one on the same lane. Here the words must keep the older time while the valid bit and flag drop. The bench reaches it with a directed pair of back-to-back strobes under mode 1: a PTP event frame first, then a general frame. It then changes the mode with no strobe present. It also uses a time value with every kept seconds bit and every nanoseconds bit set, and fires both lanes in one cycle, before a long run of random strobes, classes and modes.

// File: rtl/dts_pkg.sv
package dts_pkg;
  typedef enum logic [1:0] {
    CAP_OFF   = 2'd0,
    CAP_EVENT = 2'd1,
    CAP_PTP   = 2'd2,
    CAP_ALL   = 2'd3
  } cap_mode_e;

  typedef enum logic [1:0] {
    FR_OTHER     = 2'd0,
    FR_PTP_GEN   = 2'd1,
    FR_PTP_EVENT = 2'd2,
    FR_RSVD      = 2'd3
  } frame_class_e;

  localparam int NUM_LANES = 2;
endpackage

// File: rtl/dts_class_filter.sv
module dts_class_filter
  import dts_pkg::*;
(
  input  logic [1:0] mode,
  input  logic [1:0] fclass,
  output logic       accept
);
  cap_mode_e    m;
  frame_class_e c;
  logic         is_event;
  logic         is_ptp;

  always_comb begin
    m        = cap_mode_e'(mode);
    c        = frame_class_e'(fclass);
    is_event = (c == FR_PTP_EVENT);
    is_ptp   = is_event || (c == FR_PTP_GEN);
    unique case (m)
      CAP_OFF:   accept = 1'b0;
      CAP_EVENT: accept = is_event;
      CAP_PTP:   accept = is_ptp;
      default:   accept = 1'b1;
    endcase
  end
endmodule

// File: rtl/dts_word_packer.sv
module dts_word_packer #(
  parameter int NS_W     = 30,
  parameter int SEC_KEEP = 6,
  parameter int SEC_LO   = 2,
  parameter int WORD_W   = 32
) (
  input  logic [SEC_KEEP-1:0] sec_bits,
  input  logic [NS_W-1:0]     ns,
  output logic [WORD_W-1:0]   word1,
  output logic [WORD_W-1:0]   word2
);
  localparam int SEC_HI = SEC_KEEP - SEC_LO;

  always_comb begin
    word1                    = '0;
    word1[NS_W-1:0]          = ns;
    word1[NS_W +: SEC_LO]    = sec_bits[SEC_LO-1:0];
    word2                    = '0;
    word2[SEC_HI-1:0]        = sec_bits[SEC_KEEP-1:SEC_LO];
  end
endmodule

// File: rtl/dts_lane.sv
module dts_lane #(
  parameter int NS_W     = 30,
  parameter int SEC_KEEP = 6,
  parameter int SEC_LO   = 2,
  parameter int WORD_W   = 32,
  parameter int FLAG_BIT = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sof,
  input  logic [1:0]          fclass,
  input  logic [1:0]          mode,
  input  logic [SEC_KEEP-1:0] sec_bits,
  input  logic [NS_W-1:0]     ns,
  output logic                wr,
  output logic                valid,
  output logic [WORD_W-1:0]   word1,
  output logic [WORD_W-1:0]   word2,
  output logic [WORD_W-1:0]   flag
);
  localparam logic [WORD_W-1:0] FLAG_MASK = WORD_W'(1) << FLAG_BIT;

  logic              accept;
  logic [WORD_W-1:0] pk1;
  logic [WORD_W-1:0] pk2;

  dts_class_filter u_filter (
    .mode   (mode),
    .fclass (fclass),
    .accept (accept)
  );

  dts_word_packer #(
    .NS_W(NS_W), .SEC_KEEP(SEC_KEEP), .SEC_LO(SEC_LO), .WORD_W(WORD_W)
  ) u_pack (
    .sec_bits (sec_bits),
    .ns       (ns),
    .word1    (pk1),
    .word2    (pk2)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr    <= 1'b0;
      valid <= 1'b0;
      word1 <= '0;
      word2 <= '0;
      flag  <= '0;
    end else begin
      wr <= sof && accept;
      if (sof) begin
        valid <= accept;
        flag  <= accept ? FLAG_MASK : '0;
      end
      if (sof && accept) begin
        word1 <= pk1;
        word2 <= pk2;
      end
    end
  end
endmodule

// File: rtl/dts_stamp_capture.sv
module dts_stamp_capture
  import dts_pkg::*;
#(
  parameter int NS_W        = 30,
  parameter int SEC_KEEP    = 6,
  parameter int SEC_LO      = 2,
  parameter int WORD_W      = 32,
  parameter int RX_FLAG_BIT = 2,
  parameter int TX_FLAG_BIT = 23
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SEC_KEEP-1:0] tod_sec_lo,
  input  logic [NS_W-1:0]     tod_ns,
  input  logic [1:0]          rx_mode,
  input  logic [1:0]          tx_mode,
  input  logic                rx_sof,
  input  logic [1:0]          rx_class,
  input  logic                tx_sof,
  input  logic [1:0]          tx_class,
  output logic                rx_wr,
  output logic                rx_valid,
  output logic [WORD_W-1:0]   rx_word1,
  output logic [WORD_W-1:0]   rx_word2,
  output logic [WORD_W-1:0]   rx_flag,
  output logic                tx_wr,
  output logic                tx_valid,
  output logic [WORD_W-1:0]   tx_word1,
  output logic [WORD_W-1:0]   tx_word2,
  output logic [WORD_W-1:0]   tx_flag
);
  logic              sof_a   [NUM_LANES];
  logic [1:0]        class_a [NUM_LANES];
  logic [1:0]        mode_a  [NUM_LANES];
  logic              wr_a    [NUM_LANES];
  logic              valid_a [NUM_LANES];
  logic [WORD_W-1:0] w1_a    [NUM_LANES];
  logic [WORD_W-1:0] w2_a    [NUM_LANES];
  logic [WORD_W-1:0] flag_a  [NUM_LANES];

  assign sof_a[0]   = rx_sof;
  assign sof_a[1]   = tx_sof;
  assign class_a[0] = rx_class;
  assign class_a[1] = tx_class;
  assign mode_a[0]  = rx_mode;
  assign mode_a[1]  = tx_mode;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam int LANE_FLAG = (g == 0) ? RX_FLAG_BIT : TX_FLAG_BIT;
    dts_lane #(
      .NS_W(NS_W), .SEC_KEEP(SEC_KEEP), .SEC_LO(SEC_LO),
      .WORD_W(WORD_W), .FLAG_BIT(LANE_FLAG)
    ) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .sof      (sof_a[g]),
      .fclass   (class_a[g]),
      .mode     (mode_a[g]),
      .sec_bits (tod_sec_lo),
      .ns       (tod_ns),
      .wr       (wr_a[g]),
      .valid    (valid_a[g]),
      .word1    (w1_a[g]),
      .word2    (w2_a[g]),
      .flag     (flag_a[g])
    );
  end

  assign rx_wr    = wr_a[0];
  assign rx_valid = valid_a[0];
  assign rx_word1 = w1_a[0];
  assign rx_word2 = w2_a[0];
  assign rx_flag  = flag_a[0];
  assign tx_wr    = wr_a[1];
  assign tx_valid = valid_a[1];
  assign tx_word1 = w1_a[1];
  assign tx_word2 = w2_a[1];
  assign tx_flag  = flag_a[1];
endmodule

// File: rtl/dts_stamp_capture_chk.sv
module dts_stamp_capture_chk #(
  parameter int SEC_KEEP    = 6,
  parameter int SEC_LO      = 2,
  parameter int WORD_W      = 32,
  parameter int RX_FLAG_BIT = 2,
  parameter int TX_FLAG_BIT = 23
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_sof,
  input logic              tx_sof,
  input logic [1:0]        rx_mode,
  input logic [1:0]        tx_mode,
  input logic              rx_wr,
  input logic              tx_wr,
  input logic              rx_valid,
  input logic              tx_valid,
  input logic [WORD_W-1:0] rx_word1,
  input logic [WORD_W-1:0] rx_word2,
  input logic [WORD_W-1:0] tx_word1,
  input logic [WORD_W-1:0] tx_word2,
  input logic [WORD_W-1:0] rx_flag,
  input logic [WORD_W-1:0] tx_flag
);
  localparam int SEC_HI = SEC_KEEP - SEC_LO;
  localparam logic [WORD_W-1:0] RX_MASK = WORD_W'(1) << RX_FLAG_BIT;
  localparam logic [WORD_W-1:0] TX_MASK = WORD_W'(1) << TX_FLAG_BIT;

  assert_rx_wr_after_sof_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_wr |-> $past(rx_sof));
  assert_tx_wr_after_sof_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr |-> $past(tx_sof));

  assert_rx_word2_top_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_word2[WORD_W-1:SEC_HI] == '0);
  assert_tx_word2_top_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_word2[WORD_W-1:SEC_HI] == '0);

  assert_rx_flag_pos_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_flag & ~RX_MASK) == '0 && ((rx_flag == RX_MASK) == rx_valid));
  assert_tx_flag_pos_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_flag & ~TX_MASK) == '0 && ((tx_flag == TX_MASK) == tx_valid));

  assert_rx_mode_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_wr |-> $past(rx_mode) != 2'd0);
  assert_tx_mode_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr |-> $past(tx_mode) != 2'd0);

  assert_rx_hold_words_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_wr |-> ($stable(rx_word1) && $stable(rx_word2)));
  assert_tx_hold_words_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_wr |-> ($stable(tx_word1) && $stable(tx_word2)));

  assert_rx_valid_only_sof_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rx_sof) |-> $stable(rx_valid));
  assert_tx_valid_only_sof_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tx_sof) |-> $stable(tx_valid));
endmodule

bind dts_stamp_capture dts_stamp_capture_chk #(
  .SEC_KEEP(SEC_KEEP), .SEC_LO(SEC_LO), .WORD_W(WORD_W),
  .RX_FLAG_BIT(RX_FLAG_BIT), .TX_FLAG_BIT(TX_FLAG_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .tx_sof(tx_sof),
  .rx_mode(rx_mode), .tx_mode(tx_mode), .rx_wr(rx_wr), .tx_wr(tx_wr),
  .rx_valid(rx_valid), .tx_valid(tx_valid),
  .rx_word1(rx_word1), .rx_word2(rx_word2),
  .tx_word1(tx_word1), .tx_word2(tx_word2),
  .rx_flag(rx_flag), .tx_flag(tx_flag)
);

// File: tb/dts_stamp_capture_bench.sv
module dts_stamp_capture_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  tod_sec_lo = '0;
  logic [29:0] tod_ns = '0;
  logic [1:0]  rx_mode = '0, tx_mode = '0;
  logic        rx_sof = 1'b0, tx_sof = 1'b0;
  logic [1:0]  rx_class = '0, tx_class = '0;
  logic        rx_wr, rx_valid, tx_wr, tx_valid;
  logic [31:0] rx_word1, rx_word2, rx_flag, tx_word1, tx_word2, tx_flag;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // reference state, index 0 = receive, 1 = transmit
  bit          m_wr [2];
  bit          m_valid [2];
  logic [31:0] m_w1 [2];
  logic [31:0] m_w2 [2];
  logic [31:0] m_flag [2];

  always #10 clk = ~clk;

  dts_stamp_capture u_dts_stamp_capture (
    .clk(clk), .rst_n(rst_n), .tod_sec_lo(tod_sec_lo), .tod_ns(tod_ns),
    .rx_mode(rx_mode), .tx_mode(tx_mode), .rx_sof(rx_sof), .rx_class(rx_class),
    .tx_sof(tx_sof), .tx_class(tx_class),
    .rx_wr(rx_wr), .rx_valid(rx_valid), .rx_word1(rx_word1), .rx_word2(rx_word2),
    .rx_flag(rx_flag), .tx_wr(tx_wr), .tx_valid(tx_valid), .tx_word1(tx_word1),
    .tx_word2(tx_word2), .tx_flag(tx_flag)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // R5 admission rule
  function automatic bit admits(input logic [1:0] mode, input logic [1:0] c);
    case (mode)
      2'd0: return 1'b0;
      2'd1: return c == 2'd2;
      2'd2: return (c == 2'd1) || (c == 2'd2);
      default: return 1'b1;
    endcase
  endfunction

  task automatic compare_all();
    chk("R1 rx write strobe", {31'b0, rx_wr}, {31'b0, m_wr[0]});
    chk("R1 tx write strobe", {31'b0, tx_wr}, {31'b0, m_wr[1]});
    chk("R6 rx valid", {31'b0, rx_valid}, {31'b0, m_valid[0]});
    chk("R6 tx valid", {31'b0, tx_valid}, {31'b0, m_valid[1]});
    chk("R2 rx word1", rx_word1, m_w1[0]);
    chk("R2 tx word1", tx_word1, m_w1[1]);
    chk("R3 rx word2", rx_word2, m_w2[0]);
    chk("R3 tx word2", tx_word2, m_w2[1]);
    chk("R4 rx flag", rx_flag, m_flag[0]);
    chk("R4 tx flag", tx_flag, m_flag[1]);
  endtask

  task automatic lane_update(input int l, input bit sof, input logic [1:0] mode,
                             input logic [1:0] c, input logic [5:0] s, input logic [29:0] n);
    bit a;
    a = admits(mode, c);
    m_wr[l] = sof && a;
    if (sof) begin
      m_valid[l] = a;
      m_flag[l]  = a ? ((l == 0) ? 32'h0000_0004 : 32'h0080_0000) : 32'h0;
    end
    if (sof && a) begin
      m_w1[l] = {s[1:0], n};
      m_w2[l] = {28'b0, s[5:2]};
    end
  endtask

  // compare outputs, then drive the next cycle's inputs and advance the model
  task automatic step(input bit rs, input logic [1:0] rc, input bit ts, input logic [1:0] tc,
                      input logic [1:0] rm, input logic [1:0] tm,
                      input logic [5:0] s, input logic [29:0] n);
    @(negedge clk);
    compare_all();
    rx_sof = rs; rx_class = rc; tx_sof = ts; tx_class = tc;
    rx_mode = rm; tx_mode = tm; tod_sec_lo = s; tod_ns = n;
    lane_update(0, rs, rm, rc, s, n);
    lane_update(1, ts, tm, tc, s, n);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int l = 0; l < 2; l++) begin
      m_wr[l] = 0; m_valid[l] = 0; m_w1[l] = '0; m_w2[l] = '0; m_flag[l] = '0;
    end
    repeat (3) @(negedge clk);
    compare_all(); // R9 reset state
    rst_n = 1'b1;

    // R1/R2/R3: rx event frame, mode 1, all kept bits set
    step(1, 2'd2, 0, 2'd0, 2'd1, 2'd1, 6'h3F, 30'h3FFF_FFFF);
    // R6: rejected general frame right after; words must hold
    step(1, 2'd1, 0, 2'd0, 2'd1, 2'd1, 6'h15, 30'h0000_1234);
    // R7: mode changes with no strobe
    step(0, 2'd2, 0, 2'd0, 2'd0, 2'd3, 6'h2A, 30'h1555_5555);
    step(0, 2'd0, 0, 2'd0, 2'd3, 2'd0, 6'h01, 30'h0000_0001);
    // R8: both lanes in one cycle, different modes
    step(1, 2'd1, 1, 2'd0, 2'd2, 2'd3, 6'h2D, 30'h2AAA_AAAA);
    // R5: every mode/class pair on tx
    for (int m = 0; m < 4; m++)
      for (int c = 0; c < 4; c++)
        step(0, 2'd0, 1, 2'(c), 2'd0, 2'(m), 6'(m * 4 + c), 30'(m * 1000 + c));
    step(0, 2'd0, 0, 2'd0, 2'd0, 2'd0, 6'h0, 30'h0);
    // mixed random traffic
    for (int i = 0; i < 2000; i++)
      step(bit'($urandom_range(0, 1)), 2'($urandom), bit'($urandom_range(0, 1)),
           2'($urandom), 2'($urandom), 2'($urandom), 6'($urandom), 30'($urandom));
    step(0, 2'd0, 0, 2'd0, 2'd0, 2'd0, 6'h0, 30'h0);
    step(0, 2'd0, 0, 2'd0, 2'd0, 2'd0, 6'h0, 30'h0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule